// File: doc/BRIEF.md
# Single-Wire Bus Master

This block drives a single-wire open-drain bus with a shared pull-up. Software reaches it through three byte-wide registers. The first is a command/status register, the second is a tick divider, and the third is a block-level hold-in-reset. Software moves data one bit at a time. It sets one command bit and then polls until that bit drops. After the bit drops, it reads the status bit that belongs to the command.

A prescaler divides the system clock by (divider + 1) to give a microsecond tick. All bus timing counts in these ticks. The prescaler restarts on every accepted command, so the first slot edge has a fixed phase relative to the write. The pin side is an output-enable that pulls the line low and an input that reads the wired line. The line floats high when no device drives it.

Top module: `onewire_master`

## Requirements
- R1: After the synchronous reset, the command/status register (address 0) reads 0x00, the divider (address 2) reads DIV_INIT (default 99), the hold register (address 4) reads 0x00, and `line_oe` is 0.
- R2: The divider register reads back what was written. With divider value D, one tick lasts D+1 clock cycles, counted from the write edge that starts the command.
- R3: Writing bit 5 of address 0 starts a drive-low slot. `line_oe` is 1 for exactly 60 ticks. Bit 5 reads 1 during the slot and clears when the slot ends.
- R4: Writing bit 4 starts a sample slot. `line_oe` is 1 for exactly 1 tick. Bit 3 takes the line level present at tick 15. Bit 4 stays 1 for 60 ticks in total and then clears.
- R5: Writing bit 7 starts a bus-reset sequence. `line_oe` is 1 for 511 ticks. The line is then released for a 512-tick listen window. Bit 7 reads 1 until that window closes.
- R6: Bit 6 is cleared when a bus-reset sequence starts. It is set if the line is seen low at any clock inside the listen window.
- R7: When several command bits are written together, only one command starts. Bit 7 has priority over bit 5, and bit 5 has priority over bit 4.
- R8: A command write that arrives while a slot or sequence is running is ignored. The running slot keeps its length, and the status bits are not disturbed.
- R9: Writing 1 to bit 0 of address 4 holds the block in reset. `line_oe` goes to 0 and address 0 reads 0x00 from the next cycle on. Command writes are ignored until 0 is written back.
- R10: Bits 6 and 3 are read-only. A write to address 0 that starts no command leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register byte address (0, 2 or 4) |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| line_oe | output | 1 | 1 pulls the bus line low |
| line_in | input | 1 | Level of the wired bus line |

## Verification
The bench measures each slot length in clock cycles at two divider settings. A prescaler that is off by one, or that free-runs instead of restarting on a command, shows up as a pulse that is a few cycles too long or too short. In the sample slot, a device model holds the line low past tick 15 in one run and leaves it released in another. A design that samples at the wrong tick, or that keeps a stale value, returns the wrong bit. Command writes with several bits set, and command writes made while a slot is running, check that the block arbitrates and ignores correctly; a wrong design would start the wrong slot or a second one, or would clear the listen result. The hold-in-reset test checks that the drive is dropped at once and that commands stay locked out until the hold is released.

// File: rtl/onewire_pkg.sv
package onewire_pkg;

    localparam logic [2:0] ADDR_CTRL = 3'd0;
    localparam logic [2:0] ADDR_DIV  = 3'd2;
    localparam logic [2:0] ADDR_HOLD = 3'd4;

    // bit positions in the command/status byte
    localparam int BIT_BUSRST = 7;
    localparam int BIT_ANSWER = 6;
    localparam int BIT_LOW    = 5;
    localparam int BIT_SAMPLE = 4;
    localparam int BIT_LEVEL  = 3;

    // timing in microsecond ticks
    localparam int T_RST_LOW   = 511;
    localparam int T_RST_LISTEN = 512;
    localparam int T_SLOT      = 60;
    localparam int T_SHORT_LOW = 1;
    localparam int T_SAMPLE    = 15;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RST_LOW, ST_RST_LISTEN, ST_LOW_SLOT, ST_SAMPLE_SLOT
    } ow_state_e;

    typedef enum logic [1:0] {
        CMD_NONE, CMD_BUSRST, CMD_LOW, CMD_SAMPLE
    } ow_cmd_e;

    typedef struct packed {
        logic busrst_busy;
        logic answer;
        logic low_busy;
        logic sample_busy;
        logic level;
    } ow_status_t;

    function automatic ow_cmd_e pick_cmd(input logic [7:0] wd);
        if (wd[BIT_BUSRST])      return CMD_BUSRST;
        else if (wd[BIT_LOW])    return CMD_LOW;
        else if (wd[BIT_SAMPLE]) return CMD_SAMPLE;
        else                     return CMD_NONE;
    endfunction

endpackage

// File: rtl/ow_prescaler.sv
module ow_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= divisor);

    always_ff @(posedge clk) begin
        if (rst || restart || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine
    import onewire_pkg::*;
#(
    parameter int RST_LOW    = T_RST_LOW,
    parameter int RST_LISTEN = T_RST_LISTEN,
    parameter int SLOT       = T_SLOT,
    parameter int SHORT_LOW  = T_SHORT_LOW,
    parameter int SAMPLE_AT  = T_SAMPLE,
    localparam int CNT_W     = $clog2(RST_LISTEN + 1)
) (
    input  logic       clk,
    input  logic       clr,
    input  ow_cmd_e    cmd,
    input  logic       tick,
    input  logic       line_in,
    output logic       accept,
    output logic       line_oe,
    output ow_status_t status
);
    ow_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic             answer_q;
    logic             level_q;

    assign accept = !clr && (state == ST_IDLE) && (cmd != CMD_NONE);

    assign line_oe = (state == ST_RST_LOW) || (state == ST_LOW_SLOT) ||
                     ((state == ST_SAMPLE_SLOT) && (cnt < CNT_W'(SHORT_LOW)));

    assign status = '{busrst_busy: (state == ST_RST_LOW) || (state == ST_RST_LISTEN),
                      answer:      answer_q,
                      low_busy:    (state == ST_LOW_SLOT),
                      sample_busy: (state == ST_SAMPLE_SLOT),
                      level:       level_q};

    always_ff @(posedge clk) begin
        if (clr) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            answer_q <= 1'b0;
            level_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    unique case (cmd)
                        CMD_BUSRST: begin
                            state    <= ST_RST_LOW;
                            answer_q <= 1'b0;
                        end
                        CMD_LOW:    state <= ST_LOW_SLOT;
                        CMD_SAMPLE: state <= ST_SAMPLE_SLOT;
                        default:    state <= ST_IDLE;
                    endcase
                end
                ST_RST_LOW: if (tick) begin
                    if (cnt == CNT_W'(RST_LOW - 1)) begin
                        state <= ST_RST_LISTEN;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                ST_RST_LISTEN: begin
                    if (!line_in) answer_q <= 1'b1;
                    if (tick) begin
                        if (cnt == CNT_W'(RST_LISTEN - 1)) state <= ST_IDLE;
                        else cnt <= cnt + 1'b1;
                    end
                end
                ST_LOW_SLOT: if (tick) begin
                    if (cnt == CNT_W'(SLOT - 1)) state <= ST_IDLE;
                    else cnt <= cnt + 1'b1;
                end
                ST_SAMPLE_SLOT: if (tick) begin
                    if (cnt == CNT_W'(SAMPLE_AT - 1)) level_q <= line_in;
                    if (cnt == CNT_W'(SLOT - 1)) state <= ST_IDLE;
                    else cnt <= cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/onewire_master.sv
module onewire_master
    import onewire_pkg::*;
#(
    parameter int         DIV_W    = 8,
    parameter logic [7:0] DIV_INIT = 8'd99
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       line_oe,
    input  logic       line_in
);
    logic [DIV_W-1:0] divisor;
    logic             soft_rst;
    logic             tick;
    logic             accept;
    ow_cmd_e          cmd;
    ow_status_t       st;
    logic [2:0]       busy_vec;
    logic [7:0]       ctrl_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            divisor  <= DIV_W'(DIV_INIT);
            soft_rst <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_DIV)  divisor  <= DIV_W'(bus_wdata);
            if (bus_addr == ADDR_HOLD) soft_rst <= bus_wdata[0];
        end
    end

    assign cmd = (bus_wr && bus_addr == ADDR_CTRL && !soft_rst) ?
                 pick_cmd(bus_wdata) : CMD_NONE;

    ow_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk     (clk),
        .rst     (rst || soft_rst),
        .restart (accept),
        .divisor (divisor),
        .tick    (tick)
    );

    ow_slot_engine u_engine (
        .clk     (clk),
        .clr     (rst || soft_rst),
        .cmd     (cmd),
        .tick    (tick),
        .line_in (line_in),
        .accept  (accept),
        .line_oe (line_oe),
        .status  (st)
    );

    assign busy_vec = {st.busrst_busy, st.low_busy, st.sample_busy};

    always_comb begin
        ctrl_byte             = 8'h00;
        ctrl_byte[BIT_BUSRST] = st.busrst_busy;
        ctrl_byte[BIT_ANSWER] = st.answer;
        ctrl_byte[BIT_LOW]    = st.low_busy;
        ctrl_byte[BIT_SAMPLE] = st.sample_busy;
        ctrl_byte[BIT_LEVEL]  = st.level;
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = ctrl_byte;
            ADDR_DIV:  bus_rdata = 8'(divisor);
            ADDR_HOLD: bus_rdata = {7'b0, soft_rst};
            default:   bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/ow_checker.sv
module ow_checker (
    input logic       clk,
    input logic       rst,
    input logic       line_oe,
    input logic       soft_rst,
    input logic [2:0] busy_vec,
    input logic       answer
);
    AST_ONE_SLOT_KIND: assert property (@(posedge clk) disable iff (rst)
        $onehot0(busy_vec)); // R7
    AST_DRIVE_NEEDS_SLOT: assert property (@(posedge clk) disable iff (rst)
        line_oe |-> (busy_vec != 3'b000)); // R5
    AST_LOW_SLOT_DRIVES: assert property (@(posedge clk) disable iff (rst)
        busy_vec[1] |-> line_oe); // R3
    AST_ANSWER_CLEARED: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_vec[2]) |-> !answer); // R6
    AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy_vec != 3'b000) |=> (busy_vec == $past(busy_vec) || busy_vec == 3'b000)); // R8
    AST_HOLD_RELEASES: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (!line_oe && busy_vec == 3'b000)); // R9
endmodule

bind onewire_master ow_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .line_oe  (line_oe),
    .soft_rst (soft_rst),
    .busy_vec (busy_vec),
    .answer   (st.answer)
);

// File: tb/test_onewire_master.sv
`timescale 1ns/1ps
module test_onewire_master;
    localparam int N = 4; // divider 3

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       line_oe;
    logic       line_in;
    logic       slave_pull = 1'b0;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    int slave_mode = 0; // 0 silent, 1 answers after release, 2 holds low in sample slot
    int pull_cnt = 0;
    int delay_cnt = 0;
    logic prev_oe = 1'b0;

    always #5 clk = ~clk;

    assign line_in = !(line_oe || slave_pull);

    onewire_master i_onewire_master (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .line_oe(line_oe), .line_in(line_in)
    );

    always @(negedge clk) begin
        if (slave_mode == 2 && line_oe && !prev_oe) pull_cnt = 30 * N;
        if (slave_mode == 1 && !line_oe && prev_oe) delay_cnt = 20;
        if (delay_cnt > 0) begin
            delay_cnt--;
            if (delay_cnt == 0) pull_cnt = 100;
        end
        slave_pull = (pull_cnt > 0);
        if (pull_cnt > 0) pull_cnt--;
        prev_oe = line_oe;
    end

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // called at a negedge; consumes one clock
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic count_oe(output int n);
        n = 0;
        while (line_oe && n < 100000) begin n++; @(negedge clk); end
    endtask

    task automatic count_ctrl_bit(input int b, output int n);
        n = 0;
        bus_addr = 3'd0;
        #1;
        while (bus_rdata[b] && n < 100000) begin n++; @(negedge clk); #1; end
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        rd(3'd0, d); check("R1 ctrl", d, 0);
        rd(3'd2, d); check("R1 divider", d, 99);
        rd(3'd4, d); check("R1 hold", d, 0);
        check("R1 line_oe", line_oe, 0);
    endtask

    task automatic t_divider();
        logic [7:0] d; int n;
        wr(3'd2, 8'd1); rd(3'd2, d); check("R2 readback 1", d, 1);
        wr(3'd0, 8'h20); count_oe(n); check("R2 pulse at div 1", n, 60 * 2);
        wr(3'd2, 8'd3); rd(3'd2, d); check("R2 readback 3", d, 3);
    endtask

    task automatic t_low_slot();
        logic [7:0] d; int n;
        wr(3'd0, 8'h20);
        rd(3'd0, d); check("R3 busy bit5", d & 8'h38, 8'h20);
        count_oe(n); check("R3 low ticks", n, 60 * N);
        rd(3'd0, d); check("R3 bit5 cleared", d[5], 0);
    endtask

    task automatic t_sample(input int mode, input int exp_level);
        logic [7:0] d; int n; int m;
        slave_mode = mode;
        wr(3'd0, 8'h10);
        rd(3'd0, d); check("R4 busy bit4", d & 8'h30, 8'h10);
        count_oe(n); check("R4 short low", n, N);
        count_ctrl_bit(4, m); check("R4 slot length", n + m, 60 * N);
        rd(3'd0, d); check("R4 level", d[3], exp_level);
        slave_mode = 0;
    endtask

    task automatic t_readonly();
        logic [7:0] d;
        wr(3'd0, 8'h00); rd(3'd0, d); check("R10 write 00", d, 8'h08);
        wr(3'd0, 8'h48); rd(3'd0, d); check("R10 write 48", d, 8'h08);
    endtask

    task automatic t_bus_reset(input int mode, input int exp_answer);
        logic [7:0] d; int n; int m;
        slave_mode = mode;
        wr(3'd0, 8'h80);
        rd(3'd0, d); check("R5 busy bit7", d[7], 1);
        count_oe(n); check("R5 low ticks", n, 511 * N);
        count_ctrl_bit(7, m); check("R5 listen ticks", m, 512 * N);
        rd(3'd0, d); check("R6 answer", d[6], exp_answer);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] d; int n;
        n = 0;
        wr(3'd0, 8'h20);
        repeat (5) begin if (line_oe) n++; @(negedge clk); end
        if (line_oe) n++;
        wr(3'd0, 8'h90);
        while (line_oe && n < 100000) begin n++; @(negedge clk); end
        check("R8 slot length kept", n, 60 * N);
        rd(3'd0, d); check("R8 no second command", d & 8'hF0, 8'h40);
    endtask

    task automatic t_priority();
        logic [7:0] d; int n; int m;
        wr(3'd0, 8'hB0);
        rd(3'd0, d); check("R7 reset wins", d & 8'hB0, 8'h80);
        count_oe(n); check("R7 reset pulse", n, 511 * N);
        count_ctrl_bit(7, m);
        wr(3'd0, 8'h30);
        rd(3'd0, d); check("R7 low beats sample", d & 8'h30, 8'h20);
        count_oe(n); check("R7 low pulse", n, 60 * N);
    endtask

    task automatic t_hold();
        logic [7:0] d; int n;
        wr(3'd0, 8'h20);
        repeat (10) @(negedge clk);
        wr(3'd4, 8'h01);
        @(negedge clk);
        check("R9 drive dropped", line_oe, 0);
        rd(3'd0, d); check("R9 ctrl cleared", d, 0);
        rd(3'd4, d); check("R9 hold readback", d, 1);
        wr(3'd0, 8'h20);
        @(negedge clk);
        check("R9 command locked out", line_oe, 0);
        rd(3'd0, d); check("R9 ctrl still idle", d, 0);
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h20);
        count_oe(n); check("R9 works after release", n, 60 * N);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_divider();
        t_low_slot();
        t_sample(2, 0);
        t_sample(0, 1);
        t_readonly();
        t_bus_reset(0, 0);
        t_bus_reset(1, 1);
        t_busy_ignore();
        t_priority();
        t_hold();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule